// File: doc/BRIEF.md
# Half-Duplex Collision-Aware Bit Transmitter

This block serializes an outgoing frame onto a shared half-duplex line one bit per bit-time. The bit-time is marked by a single-cycle `bit_tick` enable; every decision, comparison and counter step happens only on that enable. The upstream source presents frame bits through a ready/valid pair and flags the final bit. While each bit is on the line, the block listens to the receive line. At the end of the bit-time it compares what it heard with what it drove.

A round-trip watch window runs from the first bit of the frame. If the two lines disagree on any bit inside the window, the block treats this as a collision. It abandons the frame and drives an alternating jam pattern instead of the remaining bits. It also pulses a backoff request. That request comes from the collision itself, so it arrives one cycle after the detecting bit-tick, well before the jam ends. Once the window has fully elapsed, disagreements are treated as beyond the block's concern. The rest of the frame, trailing CRC included, goes out untouched.

At the end of either path the transmit enable drops, and a one-cycle completion strobe reports whether the attempt collided. A constant slot-time value, the window length plus the jam length, is presented for a downstream backoff timer.

Top module: `csmacd_tx_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_en`, `tx_bit`, `done`, `collided` and `backoff_start` are low. A reset in the middle of a frame drops `tx_en` at the next clock edge.
- R2: `bit_ready` is high only in cycles where `bit_tick` is high. Each accepted frame bit is driven on `tx_bit` with `tx_en` high for exactly the bit-time that follows its acceptance. Accepted bits appear in the order they were accepted.
- R3: A collision occurs when, on a bit-tick in the send phase, `rx_bit` differs from the `tx_bit` being driven. After a collision, no further frame bits are accepted or driven.
- R4: After a collision the line carries exactly 48 jam bits, one per bit-time, starting with 1 and alternating (1,0,1,0,...). The first jam bit appears in the bit-time right after the detecting tick.
- R5: `backoff_start` is a single-cycle pulse in the clock cycle right after the detecting bit-tick. It occurs while `tx_en` is still high, once per collided frame, and never for a frame that did not collide.
- R6: The watch window covers the first 464 bits of a frame, numbered from 0. A mismatch on bit 463 is a collision. A mismatch on bit 464 or later is ignored, and the whole frame, including its last 32 bits, is sent.
- R7: One cycle after the tick that ends the last frame bit or the 48th jam bit, `done` pulses for one cycle with `tx_en` low. `collided` is 1 after a jam and 0 after a clean frame.
- R8: `slot_time` reads 512, which is the window length plus the jam length.
- R9: `tx_bit` and `tx_en` change only in the cycle after a bit-tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-time enable |
| frame_valid | input | 1 | Source has a frame bit on `frame_bit` |
| frame_bit | input | 1 | Next frame bit |
| frame_last | input | 1 | The presented bit is the final one of the frame |
| bit_ready | output | 1 | Presented bit is taken this cycle when `frame_valid` is high |
| tx_bit | output | 1 | Bit driven onto the line |
| tx_en | output | 1 | Line driver enable |
| rx_bit | input | 1 | Bit heard on the line |
| done | output | 1 | One-cycle end-of-attempt strobe |
| collided | output | 1 | Outcome of the last attempt, valid with `done` |
| backoff_start | output | 1 | One-cycle request to begin backoff |
| slot_time | output | 16 | Constant slot length in bit-times |

## Verification
The embedded properties assume three things about the inputs. `bit_tick` is a clean one-cycle enable. `rx_bit` only matters at the tick, so it may change freely between ticks. Once a frame has started, the source keeps `frame_valid` high until its final bit is taken. The bench meets these assumptions by issuing a tick every fourth clock and presenting each frame bit as soon as the previous one is taken. It builds the receive line from the transmit line and flips a single chosen bit index to place mismatches at bit 0, at the last bit of a short frame, at 463, at 464 and in mid-window.

// File: rtl/csmacd_pkg.sv
package csmacd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_JAM  = 2'd2
   } tx_state_e;

   localparam int unsigned RT_WINDOW_DEF = 464;
   localparam int unsigned JAM_LEN_DEF   = 48;
endpackage

// File: rtl/csmacd_win_cnt.sv
module csmacd_win_cnt #(
   parameter int unsigned WINDOW_BITS = 464
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic step,
   output logic in_window
);
   localparam int unsigned WCW = $clog2(WINDOW_BITS + 1);

   if (WINDOW_BITS < 1) begin : g_bad_window
      $error("WINDOW_BITS must be at least 1");
   end

   logic [WCW-1:0] cnt;

   assign in_window = (cnt < WCW'(WINDOW_BITS));

   always_ff @(posedge clk) begin
      if (rst || clear) cnt <= '0;
      else if (step && in_window) cnt <= cnt + 1'b1;
   end

   p_win_sat_r6: assert property (@(posedge clk) disable iff (rst)
      cnt <= WCW'(WINDOW_BITS));
   p_win_mono_r6: assert property (@(posedge clk) disable iff (rst)
      (!in_window && !clear) |=> !in_window);
endmodule

// File: rtl/csmacd_jam_gen.sv
module csmacd_jam_gen #(
   parameter int unsigned JAM_BITS = 48,
   parameter bit          JAM_LEAD = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic step,
   output logic jam_bit,
   output logic jam_last
);
   localparam int unsigned JCW = (JAM_BITS > 2) ? $clog2(JAM_BITS) : 1;

   if (JAM_BITS < 2 || (JAM_BITS % 2) != 0) begin : g_bad_jam
      $error("JAM_BITS must be an even count of at least 2");
   end

   logic [JCW-1:0] cnt;

   if (JAM_LEAD) begin : g_lead_one
      assign jam_bit = ~cnt[0];
   end else begin : g_lead_zero
      assign jam_bit = cnt[0];
   end

   assign jam_last = (cnt == JCW'(JAM_BITS - 1));

   always_ff @(posedge clk) begin
      if (rst || start) cnt <= '0;
      else if (step && !jam_last) cnt <= cnt + 1'b1;
   end

   p_jam_alt_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(step) && !$past(jam_last) && !$past(start) && !$past(rst)) |-> (jam_bit != $past(jam_bit)));
endmodule

// File: rtl/csmacd_tx_ctrl.sv
module csmacd_tx_ctrl
   import csmacd_pkg::*;
#(
   parameter int unsigned WINDOW_BITS = RT_WINDOW_DEF,
   parameter int unsigned JAM_BITS    = JAM_LEN_DEF,
   parameter int unsigned SLOT_W      = 16,
   parameter bit          JAM_LEAD    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              frame_valid,
   input  logic              frame_bit,
   input  logic              frame_last,
   output logic              bit_ready,
   output logic              tx_bit,
   output logic              tx_en,
   input  logic              rx_bit,
   output logic              done,
   output logic              collided,
   output logic              backoff_start,
   output logic [SLOT_W-1:0] slot_time
);
   localparam int unsigned SLOT_BITS = WINDOW_BITS + JAM_BITS;

   if (SLOT_BITS >= (64'd1 << SLOT_W)) begin : g_bad_slot
      $error("SLOT_W too narrow for the slot length");
   end

   tx_state_e state;
   logic      data_q, last_q;
   logic      in_window, jam_bit, jam_last;
   logic      coll_now, take, win_clear;

   assign slot_time = SLOT_W'(SLOT_BITS);
   assign coll_now  = bit_tick && (state == ST_SEND) && (rx_bit != data_q) && in_window;
   assign bit_ready = bit_tick && ((state == ST_IDLE) ||
                      ((state == ST_SEND) && !last_q && !coll_now));
   assign take      = bit_ready && frame_valid;
   assign win_clear = take && (state == ST_IDLE);

   assign tx_en  = (state != ST_IDLE);
   assign tx_bit = (state == ST_SEND) ? data_q :
                   (state == ST_JAM)  ? jam_bit : 1'b0;

   csmacd_win_cnt #(.WINDOW_BITS(WINDOW_BITS)) win_i (
      .clk      (clk),
      .rst      (rst),
      .clear    (win_clear),
      .step     (bit_tick && (state == ST_SEND)),
      .in_window(in_window)
   );

   csmacd_jam_gen #(.JAM_BITS(JAM_BITS), .JAM_LEAD(JAM_LEAD)) jam_i (
      .clk     (clk),
      .rst     (rst),
      .start   (coll_now),
      .step    (bit_tick && (state == ST_JAM)),
      .jam_bit (jam_bit),
      .jam_last(jam_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state         <= ST_IDLE;
         data_q        <= 1'b0;
         last_q        <= 1'b0;
         done          <= 1'b0;
         collided      <= 1'b0;
         backoff_start <= 1'b0;
      end else begin
         done          <= 1'b0;
         backoff_start <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (take) begin
                  data_q <= frame_bit;
                  last_q <= frame_last;
                  state  <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (coll_now) begin
                  state         <= ST_JAM;
                  backoff_start <= 1'b1;
               end else if (bit_tick && last_q) begin
                  state    <= ST_IDLE;
                  done     <= 1'b1;
                  collided <= 1'b0;
               end else if (take) begin
                  data_q <= frame_bit;
                  last_q <= frame_last;
               end
            end
            ST_JAM: begin
               if (bit_tick && jam_last) begin
                  state    <= ST_IDLE;
                  done     <= 1'b1;
                  collided <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
      bit_ready |-> bit_tick);
   p_no_late_jam_r6: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_SEND) && !in_window) |=> (state != ST_JAM));
   p_backoff_in_jam_r5: assert property (@(posedge clk) disable iff (rst)
      backoff_start |-> (tx_en && (tx_bit == JAM_LEAD)));
   p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> !tx_en);
   p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(bit_tick) && !$past(rst)) |-> ($stable(tx_bit) && $stable(tx_en)));
   p_no_ready_jam_r3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_JAM) |-> !bit_ready);
endmodule

// File: tb/csmacd_tx_ctrl_tb_top.sv
module csmacd_tx_ctrl_tb_top;
   localparam int WIN = 464;
   localparam int JAM = 48;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1, bit_tick = 1'b0, frame_valid = 1'b0, frame_bit = 1'b0, frame_last = 1'b0;
   logic bit_ready, tx_bit, tx_en, rx_bit, done, collided, backoff_start;
   logic [15:0] slot_time;
   logic corrupt = 1'b0;

   assign rx_bit = tx_bit ^ (tx_en & corrupt);

   csmacd_tx_ctrl dut_i (
      .clk(clk), .rst(rst), .bit_tick(bit_tick), .frame_valid(frame_valid),
      .frame_bit(frame_bit), .frame_last(frame_last), .bit_ready(bit_ready),
      .tx_bit(tx_bit), .tx_en(tx_en), .rx_bit(rx_bit), .done(done),
      .collided(collided), .backoff_start(backoff_start), .slot_time(slot_time)
   );

   int checks = 0, failures = 0;
   bit expq[$];
   int f_len = 0, f_coll = -1, f_seed = 0;
   bit f_active = 1'b0, exp_coll = 1'b0;
   int take_idx = 0, line_idx = 0, cyc = 0, coll_cyc = -10, tick_div = 0;
   bit done_seen = 1'b0, backoff_seen = 1'b0;
   bit prev_tick = 1'b0, prev_en = 1'b0, prev_bit = 1'b0;

   function automatic bit fbit(int k);
      return 1'(((k * 7 + f_seed) ^ (k >> 2)) & 1);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver, monitor and scoreboard comparison, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
         if (rst) begin
            tick_div = 0; bit_tick = 1'b0; corrupt = 1'b0; frame_valid = 1'b0;
            prev_tick = 1'b0; prev_en = 1'b0; prev_bit = 1'b0;
         end else begin
            bit_tick = (tick_div == 3);
            tick_div = (tick_div + 1) % 4;
            frame_valid = f_active && (take_idx < f_len);
            frame_bit   = fbit(take_idx);
            frame_last  = (take_idx == f_len - 1);
            #1;
            if (!prev_tick && prev_en)
               chk(tx_bit == prev_bit && tx_en, "R9 line held between ticks", tx_bit, prev_bit);
            if (!bit_tick)
               chk(!bit_ready, "R2 ready only on tick", bit_ready, 0);
            if (backoff_start) begin
               chk(exp_coll && !backoff_seen && cyc == coll_cyc + 1 && tx_en,
                   "R5 backoff pulse timing", cyc, coll_cyc + 1);
               backoff_seen = 1'b1;
            end
            if (done) begin
               chk(!tx_en, "R7 tx_en low at done", tx_en, 0);
               chk(collided == exp_coll, "R7 collided flag", collided, exp_coll);
               chk(expq.size() == 0, "R4 R6 all expected line bits seen", expq.size(), 0);
               chk(backoff_seen == exp_coll, "R5 backoff once per collision", backoff_seen, exp_coll);
               done_seen = 1'b1;
            end
            if (bit_tick) begin
               if (bit_ready && frame_valid) take_idx++;
               if (tx_en) begin
                  if (expq.size() == 0) begin
                     chk(1'b0, "R2 R3 unexpected line bit", line_idx, -1);
                  end else begin
                     bit e;
                     e = expq.pop_front();
                     chk(tx_bit == e, "R2 R4 line bit", tx_bit, e);
                  end
                  corrupt = (line_idx == f_coll);
                  if (corrupt) coll_cyc = cyc;
                  line_idx++;
               end else begin
                  corrupt = 1'b0;
               end
            end
            prev_tick = bit_tick; prev_en = tx_en; prev_bit = tx_bit;
         end
      end
   end

   task automatic run_frame(int len, int coll, int seed);
      int stop;
      @(posedge clk);
      f_seed = seed;
      exp_coll = (coll >= 0) && (coll < len) && (coll < WIN);
      expq.delete();
      for (int k = 0; k < len; k++) begin
         expq.push_back(fbit(k));
         if (exp_coll && k == coll) begin
            for (int j = 0; j < JAM; j++) expq.push_back(1'((j + 1) & 1));
            break;
         end
      end
      f_len = len; f_coll = coll; take_idx = 0; line_idx = 0;
      done_seen = 1'b0; backoff_seen = 1'b0; coll_cyc = -10;
      f_active = 1'b1;
      stop = cyc + len * 4 + JAM * 4 + 40;
      while (!done_seen && cyc < stop) @(posedge clk);
      chk(done_seen, "R7 done observed", done_seen, 1);
      f_active = 1'b0; f_coll = -1;
      repeat (6) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!tx_en && !tx_bit && !done && !collided && !backoff_start, "R1 reset outputs",
          {tx_en, tx_bit, done, collided, backoff_start}, 0);
      chk(slot_time == 16'd512, "R8 slot time", slot_time, 512);
      @(posedge clk) rst = 1'b0;
      @(negedge clk);
      chk(!tx_en && !done && !backoff_start, "R1 outputs after reset release",
          {tx_en, done, backoff_start}, 0);

      run_frame(40, -1, 1);    // R2 R7 short clean frame
      run_frame(10, 9, 2);     // R3 collision on final bit of short frame
      run_frame(600, 0, 3);    // R3 R4 collision on first bit
      run_frame(600, 463, 4);  // R6 last bit inside window collides
      run_frame(600, 464, 5);  // R6 first bit outside window ignored
      run_frame(500, -1, 6);   // R6 long clean frame with trailing CRC bits
      run_frame(600, 200, 7);  // R3 R5 mid-window collision

      // R1 reset in the middle of a frame
      @(posedge clk);
      f_seed = 8; f_len = 100; f_coll = -1; take_idx = 0; line_idx = 0;
      expq.delete();
      for (int k = 0; k < 100; k++) expq.push_back(fbit(k));
      f_active = 1'b1;
      repeat (60) @(posedge clk);
      rst = 1'b1;
      @(posedge clk);
      f_active = 1'b0;
      @(negedge clk);
      chk(!tx_en && !done, "R1 reset mid-frame drops tx_en", tx_en, 0);
      expq.delete();
      @(posedge clk) rst = 1'b0;
      repeat (8) @(posedge clk);
      run_frame(30, -1, 9);    // R1 block usable after mid-frame reset

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule